// File: doc/BRIEF.md
# Host Command Packet Decoder

This block sits behind a host link that delivers 16-bit words in order. It cuts the word stream into command packets. Each packet goes to one of four internal targets: a small register file, two command stacks that the acquisition sequencer later runs, and a direct command generator. Stack and generator words are forwarded one by one on a write port with a running index. Register read requests are answered by pushing words into a shared output FIFO. The link itself does not carry the answer back.

The register file holds the acquisition configuration. This covers the global mode, a delays word that packs a trigger delay and an attention timeout (both in microseconds), the scaler readout period, two source selectors for indicator lights and a front-panel output, a 24-bit trigger mask and an action word. Three more registers are read-only: a firmware identifier, a 24-bit attention status taken live from an input, and an 11-bit serial number. Several values are decoded for direct use: acquisition enable, scaler readout enable, external trigger selection, and the two delay bytes.

Top module: `cmd_packet_decoder`

## Requirements
- R1: The first word of a packet selects the target through its value with bit 2 cleared: 1 register file, 2 data stack, 3 scaler stack, 8 command generator; bit 2 set (value +4) marks a request for data.
- R2: A register write packet is header 1, subaddress, data word. The addressed register takes the data on the clock edge after the data word is accepted. Writable subaddresses are 1 mode, 2 delays, 5 scaler period, 6 light source, 7 output source, 8 trigger mask, 10 action.
- R3: A write to subaddress 8 takes a fourth word. The third word gives mask bits 15:0 and bits 7:0 of the fourth word give mask bits 23:16. A read of subaddress 8 returns the low 16 bits first, then {8'h00, bits 23:16}.
- R4: A read request is header 5 followed by a subaddress. The first reply word appears on out_valid/out_data one cycle after the subaddress is accepted. For 24-bit registers (8 and 12) the second word follows in the next cycle, and in_ready is low during that one cycle.
- R5: Subaddress 0 returns the FW_ID parameter, 12 returns attn_status (low word, then {8'h00, bits 23:16}), and 13 returns the serial number zero-extended to 16 bits. Writes to these subaddresses change nothing that a read returns.
- R6: For targets 2, 3 and 8, the second word is a count N and the next N words are forwarded. Each word appears on stk_data with stk_we high one cycle after it is accepted. stk_tgt is 0 for the data stack, 1 for the scaler stack and 2 for the generator, and stk_idx runs 0 to N-1. N = 0 ends the packet at once.
- R7: A packet with an unknown target code, or a request to a stack or generator target, uses its second word as a count. It drains that many words and produces no stack write and no reply.
- R8: acq_en_o is action bit 0. scaler_en_o is high when the scaler period is nonzero. ext_trig_o is high when the trigger mask is zero. trig_delay_o is delays bits 7:0 and attn_timeout_o is delays bits 15:8.
- R9: After reset all writable registers are zero, out_valid and stk_we are low, and in_ready is high.
- R10: A read request for a subaddress outside the map returns one zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host word present |
| in_data | input | 16 | Host word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| out_valid | output | 1 | Push strobe into the output FIFO |
| out_data | output | 16 | Reply word |
| stk_we | output | 1 | Stack or generator word strobe |
| stk_tgt | output | 2 | 0 data stack, 1 scaler stack, 2 generator |
| stk_idx | output | IDX_W | Word index within the packet |
| stk_data | output | 16 | Forwarded word |
| attn_status | input | 24 | Live attention status |
| mode_o | output | 16 | Global mode register |
| delays_o | output | 16 | Delays register |
| scaler_period_o | output | 16 | Scaler readout period |
| led_sel_o | output | 16 | Indicator light source selector |
| out_sel_o | output | 16 | Front-panel output source selector |
| trig_mask_o | output | 24 | Trigger mask |
| action_o | output | 16 | Action register |
| acq_en_o | output | 1 | Acquisition enabled |
| scaler_en_o | output | 1 | Scaler readout enabled |
| ext_trig_o | output | 1 | External input is the trigger |
| trig_delay_o | output | 8 | Trigger delay in microseconds |
| attn_timeout_o | output | 8 | Attention timeout in microseconds |

## Verification
The assertions check timing rules on every cycle. A reply word or stack strobe must follow an accepted word. A backpressure cycle lasts one cycle and carries a reply. Consecutive stack strobes count their index up and keep the same target. Stack writes and replies never collide. Framing itself can only be shown by the bench's packet scenarios: drained packets, the two-word mask, ignored read-only writes and the register values read back against a model.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
    localparam int WORD_W = 16;

    localparam logic [15:0] SA_FWID   = 16'd0;
    localparam logic [15:0] SA_MODE   = 16'd1;
    localparam logic [15:0] SA_DELAY  = 16'd2;
    localparam logic [15:0] SA_PERIOD = 16'd5;
    localparam logic [15:0] SA_LED    = 16'd6;
    localparam logic [15:0] SA_OSEL   = 16'd7;
    localparam logic [15:0] SA_MASK   = 16'd8;
    localparam logic [15:0] SA_ACTION = 16'd10;
    localparam logic [15:0] SA_ATTN   = 16'd12;
    localparam logic [15:0] SA_SERIAL = 16'd13;

    typedef enum logic [2:0] {K_REG, K_DSTK, K_SSTK, K_GEN, K_BAD} kind_e;
    typedef enum logic [2:0] {S_HDR, S_ARG, S_DATA, S_HIGH, S_STREAM, S_DRAIN, S_REPLY} fstate_e;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [15:0] sub;
        logic [23:0] data;
    } reg_req_t;

    typedef struct packed {
        logic [15:0] mode;
        logic [15:0] delays;
        logic [15:0] period;
        logic [15:0] led;
        logic [15:0] osel;
        logic [23:0] mask;
        logic [15:0] action;
    } cfg_t;

    function automatic kind_e decode_kind(input logic [15:0] w);
        logic [15:0] base;
        base = w & ~16'h0004;
        case (base)
            16'd1:   return K_REG;
            16'd2:   return K_DSTK;
            16'd3:   return K_SSTK;
            16'd8:   return K_GEN;
            default: return K_BAD;
        endcase
    endfunction

    function automatic logic [1:0] tgt_code(input kind_e k);
        case (k)
            K_SSTK:  return 2'd1;
            K_GEN:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic is_wide(input logic [15:0] sub);
        return (sub == SA_MASK) || (sub == SA_ATTN);
    endfunction
endpackage

// File: rtl/cpd_framer.sv
module cpd_framer
    import cpd_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [15:0]      in_data,
    output logic             in_ready,
    output reg_req_t         req,
    output logic             rd_hi,
    output logic             stk_we,
    output logic [1:0]       stk_tgt,
    output logic [IDX_W-1:0] stk_idx,
    output logic [15:0]      stk_data
);
    fstate_e          st;
    kind_e            kind;
    logic             req_f;
    logic [15:0]      sub;
    logic [15:0]      cnt;
    logic [15:0]      lo_pend;
    logic [IDX_W-1:0] idx;
    logic             acc;

    always_comb begin
        in_ready = (st != S_REPLY);
        acc      = in_valid && in_ready;
        rd_hi    = (st == S_REPLY);
        req.rd   = acc && (st == S_ARG) && (kind == K_REG) && req_f;
        req.wr   = acc && (((st == S_DATA) && (sub != SA_MASK)) || (st == S_HIGH));
        req.sub  = (st == S_ARG) ? in_data : sub;
        req.data = (st == S_HIGH) ? {in_data[7:0], lo_pend} : {8'h00, in_data};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_HDR;
            kind     <= K_BAD;
            req_f    <= 1'b0;
            sub      <= '0;
            cnt      <= '0;
            lo_pend  <= '0;
            idx      <= '0;
            stk_we   <= 1'b0;
            stk_tgt  <= '0;
            stk_idx  <= '0;
            stk_data <= '0;
        end else begin
            stk_we <= 1'b0;
            case (st)
                S_HDR: if (acc) begin
                    kind  <= decode_kind(in_data);
                    req_f <= in_data[2];
                    st    <= S_ARG;
                end
                S_ARG: if (acc) begin
                    if (kind == K_REG) begin
                        if (req_f) st <= is_wide(in_data) ? S_REPLY : S_HDR;
                        else begin
                            sub <= in_data;
                            st  <= S_DATA;
                        end
                    end else begin
                        cnt <= in_data;
                        idx <= '0;
                        if (in_data == 16'd0)              st <= S_HDR;
                        else if (req_f || kind == K_BAD)   st <= S_DRAIN;
                        else                               st <= S_STREAM;
                    end
                end
                S_DATA: if (acc) begin
                    if (sub == SA_MASK) begin
                        lo_pend <= in_data;
                        st      <= S_HIGH;
                    end else st <= S_HDR;
                end
                S_HIGH: if (acc) st <= S_HDR;
                S_STREAM: if (acc) begin
                    stk_we   <= 1'b1;
                    stk_data <= in_data;
                    stk_idx  <= idx;
                    stk_tgt  <= tgt_code(kind);
                    idx      <= idx + 1'b1;
                    cnt      <= cnt - 16'd1;
                    if (cnt == 16'd1) st <= S_HDR;
                end
                S_DRAIN: if (acc) begin
                    cnt <= cnt - 16'd1;
                    if (cnt == 16'd1) st <= S_HDR;
                end
                default: st <= S_HDR;
            endcase
        end
    end
endmodule

// File: rtl/cpd_regfile.sv
module cpd_regfile
    import cpd_pkg::*;
#(
    parameter logic [15:0]          FW_ID     = 16'h3A17,
    parameter int                   SERIAL_W  = 11,
    parameter logic [SERIAL_W-1:0]  SERIAL_NO = 11'h2C5
) (
    input  logic        clk,
    input  logic        rst,
    input  reg_req_t    req,
    input  logic        rd_hi,
    input  logic [23:0] attn_i,
    output cfg_t        cfg,
    output logic        out_valid,
    output logic [15:0] out_data
);
    localparam int PAD_W = WORD_W - SERIAL_W;

    logic [15:0] rd_lo, rd_hw, hi_hold;

    always_comb begin
        rd_hw = 16'h0000;
        case (req.sub)
            SA_FWID:   rd_lo = FW_ID;
            SA_MODE:   rd_lo = cfg.mode;
            SA_DELAY:  rd_lo = cfg.delays;
            SA_PERIOD: rd_lo = cfg.period;
            SA_LED:    rd_lo = cfg.led;
            SA_OSEL:   rd_lo = cfg.osel;
            SA_MASK: begin
                rd_lo = cfg.mask[15:0];
                rd_hw = {8'h00, cfg.mask[23:16]};
            end
            SA_ACTION: rd_lo = cfg.action;
            SA_ATTN: begin
                rd_lo = attn_i[15:0];
                rd_hw = {8'h00, attn_i[23:16]};
            end
            SA_SERIAL: rd_lo = {{PAD_W{1'b0}}, SERIAL_NO};
            default:   rd_lo = 16'h0000;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            hi_hold   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (req.wr) begin
                case (req.sub)
                    SA_MODE:   cfg.mode   <= req.data[15:0];
                    SA_DELAY:  cfg.delays <= req.data[15:0];
                    SA_PERIOD: cfg.period <= req.data[15:0];
                    SA_LED:    cfg.led    <= req.data[15:0];
                    SA_OSEL:   cfg.osel   <= req.data[15:0];
                    SA_MASK:   cfg.mask   <= req.data;
                    SA_ACTION: cfg.action <= req.data[15:0];
                    default: ;
                endcase
            end
            if (req.rd) begin
                out_valid <= 1'b1;
                out_data  <= rd_lo;
                hi_hold   <= rd_hw;
            end else if (rd_hi) begin
                out_valid <= 1'b1;
                out_data  <= hi_hold;
            end
        end
    end
endmodule

// File: rtl/cmd_packet_decoder.sv
module cmd_packet_decoder
    import cpd_pkg::*;
#(
    parameter int                   IDX_W     = 16,
    parameter logic [15:0]          FW_ID     = 16'h3A17,
    parameter int                   SERIAL_W  = 11,
    parameter logic [SERIAL_W-1:0]  SERIAL_NO = 11'h2C5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [15:0]      in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [15:0]      out_data,
    output logic             stk_we,
    output logic [1:0]       stk_tgt,
    output logic [IDX_W-1:0] stk_idx,
    output logic [15:0]      stk_data,
    input  logic [23:0]      attn_status,
    output logic [15:0]      mode_o,
    output logic [15:0]      delays_o,
    output logic [15:0]      scaler_period_o,
    output logic [15:0]      led_sel_o,
    output logic [15:0]      out_sel_o,
    output logic [23:0]      trig_mask_o,
    output logic [15:0]      action_o,
    output logic             acq_en_o,
    output logic             scaler_en_o,
    output logic             ext_trig_o,
    output logic [7:0]       trig_delay_o,
    output logic [7:0]       attn_timeout_o
);
    reg_req_t req;
    logic     rd_hi;
    cfg_t     cfg;

    cpd_framer #(.IDX_W(IDX_W)) framer_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .req(req), .rd_hi(rd_hi), .stk_we(stk_we),
        .stk_tgt(stk_tgt), .stk_idx(stk_idx), .stk_data(stk_data)
    );

    cpd_regfile #(.FW_ID(FW_ID), .SERIAL_W(SERIAL_W), .SERIAL_NO(SERIAL_NO)) regs_i (
        .clk(clk), .rst(rst), .req(req), .rd_hi(rd_hi), .attn_i(attn_status),
        .cfg(cfg), .out_valid(out_valid), .out_data(out_data)
    );

    always_comb begin
        mode_o          = cfg.mode;
        delays_o        = cfg.delays;
        scaler_period_o = cfg.period;
        led_sel_o       = cfg.led;
        out_sel_o       = cfg.osel;
        trig_mask_o     = cfg.mask;
        action_o        = cfg.action;
        acq_en_o        = cfg.action[0];
        scaler_en_o     = |cfg.period;
        ext_trig_o      = ~|cfg.mask;
        trig_delay_o    = cfg.delays[7:0];
        attn_timeout_o  = cfg.delays[15:8];
    end
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
    parameter int IDX_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             stk_we,
    input logic [1:0]       stk_tgt,
    input logic [IDX_W-1:0] stk_idx
);
    p_ready_gap_r4: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

    p_stall_has_reply_r4: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);

    p_reply_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_ready)) |-> $past(in_valid));

    p_stk_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
        stk_we |-> $past(in_valid && in_ready));

    p_stk_idx_step_r6: assert property (@(posedge clk) disable iff (rst)
        (stk_we && $past(stk_we)) |-> (stk_idx == $past(stk_idx) + 1'b1) && (stk_tgt == $past(stk_tgt)));

    p_no_collide_r7: assert property (@(posedge clk) disable iff (rst)
        !(stk_we && out_valid));
endmodule

bind cmd_packet_decoder cpd_checker #(.IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .stk_we(stk_we), .stk_tgt(stk_tgt), .stk_idx(stk_idx)
);

// File: tb/cmd_packet_decoder_tb_top.sv
module cmd_packet_decoder_tb_top;
    localparam logic [15:0] FWID = 16'h3A17;
    localparam logic [15:0] SER  = 16'h02C5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic in_ready, out_valid, stk_we;
    logic [15:0] out_data, stk_data;
    logic [1:0]  stk_tgt;
    logic [15:0] stk_idx;
    logic [23:0] attn_status = 24'hA5C3E1;
    logic [15:0] mode_o, delays_o, scaler_period_o, led_sel_o, out_sel_o, action_o;
    logic [23:0] trig_mask_o;
    logic acq_en_o, scaler_en_o, ext_trig_o;
    logic [7:0] trig_delay_o, attn_timeout_o;

    always #2.5 clk = ~clk;

    cmd_packet_decoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .stk_we(stk_we), .stk_tgt(stk_tgt),
        .stk_idx(stk_idx), .stk_data(stk_data), .attn_status(attn_status),
        .mode_o(mode_o), .delays_o(delays_o), .scaler_period_o(scaler_period_o),
        .led_sel_o(led_sel_o), .out_sel_o(out_sel_o), .trig_mask_o(trig_mask_o),
        .action_o(action_o), .acq_en_o(acq_en_o), .scaler_en_o(scaler_en_o),
        .ext_trig_o(ext_trig_o), .trig_delay_o(trig_delay_o), .attn_timeout_o(attn_timeout_o)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    bit done = 0;
    logic [15:0] oq[$];
    int          ot[$];
    logic [15:0] sd[$], si[$];
    logic [1:0]  stq[$];

    logic [15:0] m_mode, m_delay, m_period, m_led, m_osel, m_action;
    logic [23:0] m_mask;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (!rst) begin
        if (out_valid) begin oq.push_back(out_data); ot.push_back(cyc); end
        if (stk_we) begin sd.push_back(stk_data); si.push_back(stk_idx); stq.push_back(stk_tgt); end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic clrq();
        oq.delete(); ot.delete(); sd.delete(); si.delete(); stq.delete();
    endtask

    task automatic send(input logic [15:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_wr(input logic [15:0] sub, input logic [15:0] d, input logic [7:0] h);
        case (sub)
            16'd1:  m_mode   = d;
            16'd2:  m_delay  = d;
            16'd5:  m_period = d;
            16'd6:  m_led    = d;
            16'd7:  m_osel   = d;
            16'd8:  m_mask   = {h, d};
            16'd10: m_action = d;
            default: ;
        endcase
    endfunction

    function automatic int exp_rd(input logic [15:0] sub, output logic [15:0] lo, output logic [15:0] hi);
        hi = 16'h0000;
        case (sub)
            16'd0:  begin lo = FWID;     return 1; end
            16'd1:  begin lo = m_mode;   return 1; end
            16'd2:  begin lo = m_delay;  return 1; end
            16'd5:  begin lo = m_period; return 1; end
            16'd6:  begin lo = m_led;    return 1; end
            16'd7:  begin lo = m_osel;   return 1; end
            16'd8:  begin lo = m_mask[15:0]; hi = {8'h00, m_mask[23:16]}; return 2; end
            16'd10: begin lo = m_action; return 1; end
            16'd12: begin lo = attn_status[15:0]; hi = {8'h00, attn_status[23:16]}; return 2; end
            16'd13: begin lo = SER;      return 1; end
            default: begin lo = 16'h0000; return 1; end
        endcase
    endfunction

    task automatic wr_reg(input logic [15:0] sub, input logic [15:0] d, input logic [7:0] h);
        send(16'd1); send(sub); send(d);
        if (sub == 16'd8) send({8'h00, h});
        idle(1);
        model_wr(sub, d, h);
    endtask

    task automatic rd_reg(input logic [15:0] sub, input string rq);
        logic [15:0] lo, hi;
        int n;
        n = exp_rd(sub, lo, hi);
        clrq();
        send(16'd5); send(sub); idle(4);
        check(oq.size() == n, rq, $sformatf("reply count sub %0d", sub), oq.size(), n);
        if (oq.size() >= 1) check(oq[0] == lo, rq, $sformatf("reply low sub %0d", sub), oq[0], lo);
        if (n == 2 && oq.size() == 2) begin
            check(oq[1] == hi, rq, $sformatf("reply high sub %0d", sub), oq[1], hi);
            check(ot[1] == ot[0] + 1, "R4", "high word in next cycle", ot[1] - ot[0], 1);
        end
    endtask

    task automatic check_ports(input string rq);
        check(mode_o == m_mode, rq, "mode_o", mode_o, m_mode);
        check(delays_o == m_delay, rq, "delays_o", delays_o, m_delay);
        check(scaler_period_o == m_period, rq, "scaler_period_o", scaler_period_o, m_period);
        check(led_sel_o == m_led, rq, "led_sel_o", led_sel_o, m_led);
        check(out_sel_o == m_osel, rq, "out_sel_o", out_sel_o, m_osel);
        check(trig_mask_o == m_mask, rq, "trig_mask_o", trig_mask_o, m_mask);
        check(action_o == m_action, rq, "action_o", action_o, m_action);
    endtask

    task automatic check_derived();
        check(acq_en_o == m_action[0], "R8", "acq_en_o", acq_en_o, m_action[0]);
        check(scaler_en_o == (m_period != 0), "R8", "scaler_en_o", scaler_en_o, (m_period != 0));
        check(ext_trig_o == (m_mask == 0), "R8", "ext_trig_o", ext_trig_o, (m_mask == 0));
        check(trig_delay_o == m_delay[7:0], "R8", "trig_delay_o", trig_delay_o, m_delay[7:0]);
        check(attn_timeout_o == m_delay[15:8], "R8", "attn_timeout_o", attn_timeout_o, m_delay[15:8]);
    endtask

    task automatic stk_pkt(input logic [15:0] code, input int n, input bit fwd, input logic [1:0] tgt, input string rq);
        logic [15:0] w[16];
        clrq();
        send(code); send(16'(n));
        for (int k = 0; k < n; k++) begin
            w[k] = 16'($urandom);
            send(w[k]);
        end
        idle(4);
        check(oq.size() == 0, rq, "no reply", oq.size(), 0);
        if (fwd) begin
            check(sd.size() == n, rq, "forwarded count", sd.size(), n);
            for (int k = 0; k < n && k < sd.size(); k++) begin
                check(sd[k] == w[k], rq, "stk_data", sd[k], w[k]);
                check(si[k] == 16'(k), rq, "stk_idx", si[k], k);
                check(stq[k] == tgt, "R1", "stk_tgt", stq[k], tgt);
            end
        end else begin
            check(sd.size() == 0, rq, "nothing forwarded", sd.size(), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_mode = 0; m_delay = 0; m_period = 0; m_led = 0; m_osel = 0; m_action = 0; m_mask = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(out_valid == 0, "R9", "out_valid", out_valid, 0);
        check(stk_we == 0, "R9", "stk_we", stk_we, 0);
        check(in_ready == 1, "R9", "in_ready", in_ready, 1);
        check_ports("R9");
        check_derived();

        // R2 single register writes, R8 decoded values
        wr_reg(16'd1, 16'hBEEF, 8'h00);
        check_ports("R2");
        rd_reg(16'd1, "R4");
        wr_reg(16'd2, 16'h3C7D, 8'h00);
        wr_reg(16'd10, 16'h0001, 8'h00);
        wr_reg(16'd5, 16'h0009, 8'h00);
        check_derived();
        wr_reg(16'd5, 16'h0000, 8'h00);
        wr_reg(16'd10, 16'h0002, 8'h00);
        check_derived();

        // R3 trigger mask in two words
        wr_reg(16'd8, 16'h1234, 8'h9A);
        check(trig_mask_o == 24'h9A1234, "R3", "trig_mask_o", trig_mask_o, 24'h9A1234);
        check_derived();
        rd_reg(16'd8, "R3");
        wr_reg(16'd8, 16'h0000, 8'h00);
        check_derived();

        // R5 read-only registers
        rd_reg(16'd0, "R5");
        rd_reg(16'd12, "R5");
        rd_reg(16'd13, "R5");
        wr_reg(16'd0, 16'h1111, 8'h00);
        wr_reg(16'd13, 16'h2222, 8'h00);
        wr_reg(16'd12, 16'h3333, 8'h00);
        rd_reg(16'd0, "R5");
        rd_reg(16'd13, "R5");
        check_ports("R5");

        // R10 unknown subaddress
        rd_reg(16'd3, "R10");
        rd_reg(16'd77, "R10");

        // R6 stack and generator forwarding, R1 target codes
        stk_pkt(16'd2, 5, 1'b1, 2'd0, "R6");
        stk_pkt(16'd3, 3, 1'b1, 2'd1, "R6");
        stk_pkt(16'd8, 8, 1'b1, 2'd2, "R6");
        stk_pkt(16'd2, 0, 1'b1, 2'd0, "R6");
        rd_reg(16'd1, "R6");

        // R7 unknown targets and stack requests are drained
        stk_pkt(16'd9, 3, 1'b0, 2'd0, "R7");
        stk_pkt(16'd6, 2, 1'b0, 2'd0, "R7");
        stk_pkt(16'd0, 4, 1'b0, 2'd0, "R7");
        rd_reg(16'd8, "R7");
        check_ports("R7");

        // R2 random writes and read-backs
        for (int it = 0; it < 40; it++) begin
            logic [15:0] subs[7];
            subs = '{16'd1, 16'd2, 16'd5, 16'd6, 16'd7, 16'd8, 16'd10};
            wr_reg(subs[$urandom % 7], 16'($urandom), 8'($urandom));
            check_ports("R2");
            rd_reg(subs[$urandom % 7], "R2");
        end
        check_derived();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule